// File: doc/BRIEF.md
# Bootstrap Entry Request Detector

This block decides when a controller should leave normal execution and start its serial bootstrap loader. It watches one active-low request line, `req_n`, which idles high through a pull-up. The line may come straight from a push button or a jumper, so it is asynchronous to the clock. The line is first synchronized. A change of level is then accepted only after the new level has been present for `QUAL_CYCLES` consecutive clocks, and this rule applies both when the line goes low and when it goes high again.

A request is raised in two cases. The first is a qualified fall of the line during normal operation. The second is the line already being low when the power-on reset ends. In either case the block emits a single-cycle `enter_pulse` and sets the level output `req_active`. A second entry needs the line to be accepted as high again and then to fall again. This gives exactly one entry for each physical press, however long the press lasts.

Top module: `boot_req_detect`

## Requirements
- R1: While `rst` is high, `enter_pulse` is 0. `req_active` takes the synchronized inverse of `req_n`, so it is 1 when the line is held low and 0 when the line is held high.
- R2: If `req_n` is low when `rst` falls, `enter_pulse` is 1 for exactly one cycle. That cycle is the one following the first rising edge at which `rst` is sampled low. No further pulse follows while the line stays low.
- R3: While `req_active` is 0, holding `req_n` low sets `req_active` to 1 at the (SYNC_STAGES+QUAL_CYCLES)-th rising edge. Edge 1 is the first edge that samples the low level. With the defaults this is the 50th edge.
- R4: A low on `req_n` that is sampled for fewer than `QUAL_CYCLES` consecutive edges leaves `req_active` at 0 and produces no `enter_pulse`.
- R5: While `req_active` is 1, `req_active` returns to 0 only after `req_n` has been high for `QUAL_CYCLES` consecutive sampled edges, with the same latency as in R3. A shorter high leaves `req_active` at 1.
- R6: Each accepted transition of `req_active` from 0 to 1 during normal operation produces `enter_pulse` = 1 for exactly one cycle. That cycle is the same one in which `req_active` first reads 1.
- R7: After an entry, no new `enter_pulse` occurs until `req_active` has been accepted as 0 and a new qualified low follows.
- R8: With `req_n` held at its idle high level, `enter_pulse` and `req_active` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| req_n | input | 1 | Asynchronous active-low bootstrap request line, idle high |
| enter_pulse | output | 1 | One-cycle command to enter bootstrap loading |
| req_active | output | 1 | Accepted request level, 1 while the request is active |

## Verification
The hardest situation to reach is a level that sits right at the qualification threshold. That means a low or high lasting `QUAL_CYCLES`-1 or exactly `QUAL_CYCLES` samples. It also includes a reset that is released while the line is already low, or that strikes in the middle of a qualification run. Directed sequences count edges exactly to the threshold on both sides and in both directions. Seeded random segments are then drawn mostly within a few cycles of the threshold, with occasional resets at random line levels. Every cycle is compared against a run-length model kept in the bench.

// File: rtl/breq_pkg.sv
package breq_pkg;
  localparam int unsigned QUAL_DEFAULT = 48;
  localparam int unsigned SYNC_DEFAULT = 2;

  // Bits needed to hold counts 0 .. n-1
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/breq_sync.sv
module breq_sync #(
  parameter int unsigned STAGES = breq_pkg::SYNC_DEFAULT
) (
  input  logic clk,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  // No reset: the chain keeps sampling during reset so the accepted level can be loaded
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) pipe[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk) pipe[i] <= pipe[i-1];
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/breq_qualifier.sv
module breq_qualifier #(
  parameter int unsigned QUAL = breq_pkg::QUAL_DEFAULT
) (
  input  logic clk,
  input  logic rst,
  input  logic low_sync,
  output logic acc_low,
  output logic fall_accept
);
  localparam int unsigned CW = breq_pkg::cnt_width(QUAL);
  localparam logic [CW-1:0] LAST = CW'(QUAL - 1);

  logic [CW-1:0] cnt_q;
  logic          acc_q;
  logic          differ;
  logic          done;

  assign differ      = (low_sync != acc_q);
  assign done        = differ && (cnt_q == LAST);
  assign fall_accept = done && !acc_q && !rst;
  assign acc_low     = acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= low_sync;
      cnt_q <= '0;
    end else if (!differ) begin
      cnt_q <= '0;
    end else if (done) begin
      acc_q <= ~acc_q;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R1: reset loads the accepted level from the synchronized line
  assert_reset_load_R1: assert property (@(posedge clk)
    $past(rst) |-> (acc_q == $past(low_sync)));

  // R3: counter never runs past the qualification limit
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  // R5: accepted level changes only after a full qualifying run
  assert_flip_qualified_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(acc_q)) |->
      ($past(cnt_q) == LAST && $past(low_sync) != $past(acc_q)));

  // R4: a sample matching the accepted level restarts the run
  assert_restart_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(low_sync) == $past(acc_q)) |-> (cnt_q == '0));
endmodule

// File: rtl/breq_pulse_gen.sv
module breq_pulse_gen (
  input  logic clk,
  input  logic rst,
  input  logic acc_low,
  input  logic fall_accept,
  output logic enter_pulse
);
  logic rst_q;
  logic pulse_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= fall_accept | (rst_q & acc_low);
  end

  assign enter_pulse = pulse_q;

  // R6/R2: a pulse follows either a fresh accepted fall or the end of reset
  assert_pulse_cause_R6: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> ($rose(acc_low) || $past(rst, 2)));
endmodule

// File: rtl/boot_req_detect.sv
module boot_req_detect #(
  parameter int unsigned QUAL_CYCLES = breq_pkg::QUAL_DEFAULT,
  parameter int unsigned SYNC_STAGES = breq_pkg::SYNC_DEFAULT
) (
  input  logic clk,
  input  logic rst,
  input  logic req_n,
  output logic enter_pulse,
  output logic req_active
);
  logic sync_n;
  logic acc_low;
  logic fall_accept;

  breq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .din  (req_n),
    .dout (sync_n)
  );

  breq_qualifier #(.QUAL(QUAL_CYCLES)) u_qual (
    .clk         (clk),
    .rst         (rst),
    .low_sync    (~sync_n),
    .acc_low     (acc_low),
    .fall_accept (fall_accept)
  );

  breq_pulse_gen u_pulse (
    .clk         (clk),
    .rst         (rst),
    .acc_low     (acc_low),
    .fall_accept (fall_accept),
    .enter_pulse (enter_pulse)
  );

  assign req_active = acc_low;

  // R6: pulse only while request level is active
  assert_pulse_level_R6: assert property (@(posedge clk) disable iff (rst)
    enter_pulse |-> req_active);

  // R7: never two entry pulses back to back
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    enter_pulse |=> !enter_pulse);

  // R1: no entry pulse while reset is held
  assert_quiet_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> !enter_pulse);
endmodule

// File: tb/boot_req_detect_tb.sv
module boot_req_detect_tb;
  localparam int QUAL = 48;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_n = 1'b1;
  logic enter_pulse;
  logic req_active;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  bit auto_on = 1'b0;
  bit done_flag = 1'b0;

  boot_req_detect #(.QUAL_CYCLES(QUAL), .SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst(rst), .req_n(req_n),
    .enter_pulse(enter_pulse), .req_active(req_active)
  );

  always #5 clk = ~clk;

  // Run-length reference model, updated at each rising edge
  bit m_s1 = 1'b1, m_s2 = 1'b1, m_acc = 1'b0, m_inrst = 1'b0, m_pulse = 1'b0;
  bit m_diff;
  int m_run = 0;

  always @(posedge clk) begin
    m_diff = ((!m_s2) != m_acc);
    if (rst) begin
      m_pulse = 1'b0;
      m_acc   = !m_s2;
      m_run   = 0;
    end else begin
      m_pulse = m_inrst && m_acc;
      if (!m_diff) m_run = 0;
      else if (m_run == QUAL - 1) begin
        if (!m_acc) m_pulse = 1'b1;
        m_acc = !m_acc;
        m_run = 0;
      end else m_run++;
    end
    m_inrst = rst;
    m_s2 = m_s1;
    m_s1 = req_n;
  end

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (rst) begin
        check("R1", enter_pulse, 1'b0, "pulse during reset");
      end else if (auto_on) begin
        check("R3", req_active, m_acc, "level vs model");
        check("R6", enter_pulse, m_pulse, "pulse vs model");
      end
      if (enter_pulse) pulses++;
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #1500000;
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog R3 actual=timeout expected=finish");
      finish_run();
    end
  end

  initial begin
    int p0;
    void'($urandom(32'h0000B007));
    @(negedge clk);
    // R1 / R8: reset with idle line
    step(6);
    check("R1", req_active, 1'b0, "level in reset, line high");
    rst = 1'b0;
    auto_on = 1'b1;
    step(100);
    check("R8", req_active, 1'b0, "idle level");
    check("R8", logic'(pulses == 0), 1'b1, "idle pulse count zero");

    // R4: low one sample short
    req_n = 1'b0; step(QUAL - 1);
    req_n = 1'b1; step(60);
    check("R4", req_active, 1'b0, "short low ignored");
    check("R4", logic'(pulses == 0), 1'b1, "short low no pulse");

    // R3 / R6: exact latency of a qualified low
    req_n = 1'b0; step(SYNC + QUAL - 1);
    check("R3", req_active, 1'b0, "one edge before threshold");
    step(1);
    check("R3", req_active, 1'b1, "at threshold edge");
    check("R6", enter_pulse, 1'b1, "pulse with level rise");
    step(1);
    check("R6", enter_pulse, 1'b0, "pulse lasts one cycle");

    // R5 / R7: short high glitch while active
    p0 = pulses;
    req_n = 1'b1; step(QUAL - 1);
    req_n = 1'b0; step(60);
    check("R5", req_active, 1'b1, "short high ignored");
    check("R7", logic'(pulses == p0), 1'b1, "no re-entry without release");

    // R5: exact latency of release
    req_n = 1'b1; step(SYNC + QUAL - 1);
    check("R5", req_active, 1'b1, "one edge before release");
    step(1);
    check("R5", req_active, 1'b0, "released at threshold");
    check("R5", enter_pulse, 1'b0, "no pulse on release");

    // R7: new press after release enters again
    step(10);
    req_n = 1'b0; step(SYNC + QUAL);
    check("R7", enter_pulse, 1'b1, "second entry after release");

    // R2: reset released while line low
    rst = 1'b1; step(6);
    check("R1", req_active, 1'b1, "level in reset, line low");
    rst = 1'b0; step(1);
    check("R2", enter_pulse, 1'b1, "power-up entry pulse");
    check("R2", req_active, 1'b1, "power-up level");
    p0 = pulses;
    step(100);
    check("R2", logic'(pulses == p0), 1'b1, "single power-up pulse");

    // Random segments near the threshold, occasional resets
    for (int s = 0; s < 500; s++) begin
      int unsigned len;
      if ($urandom_range(0, 1) == 0) len = $urandom_range(QUAL - 3, QUAL + 3);
      else len = $urandom_range(1, 110);
      req_n = ~req_n;
      if ($urandom_range(0, 49) == 0) begin
        rst = 1'b1; step(3);
        rst = 1'b0;
      end
      step(int'(len));
    end
    check("R6", logic'(pulses > p0), 1'b1, "random phase produced entries");

    done_flag = 1'b1;
    finish_run();
  end
endmodule